// File: doc/BRIEF.md
# Color Mosaic Gain Steering

This block assigns one of four programmable gain codes to every pixel read out of an image sensor that sits behind a 2x2 color filter mosaic. Each pixel-valid strobe produces a channel index and its gain code one clock later. These are meant for a downstream per-pixel gain stage. The horizontal sync pulse starts a new line. The vertical sync pulse starts a new frame or field. Between them, the block tracks column parity, line parity and field parity.

Two steering modes are supported. Line-alternating mode suits progressive sensors: even lines use the first gain pair and odd lines use the second. Field-alternating mode suits interlaced sensors: every line of one field uses the first pair and every line of the other field uses the second. In both modes the two gains of a pair alternate pixel by pixel across the line. The gain codes are sampled into a shadow bank at each line start, so a code written in the middle of a line cannot change the gain partway through that line.

Top module: `cfa_gain_steer`

## Requirements
- R1: While reset is asserted and after it is released, `gainValid`, `chanOut` and `gainOut` are all zero, and every shadow gain is zero until the first line start loads it.
- R2: Channel k of `gainCodes` sits in bits [k*GAIN_W+GAIN_W-1 : k*GAIN_W]. `chanOut` equals {row bit, column bit}. `gainOut` is the shadowed gain of channel `chanOut`.
- R3: Within a line, successive valid pixels alternate column bit 0, 1, 0, 1. Cycles without a valid pixel do not advance the column. A pixel in the same cycle as `hdPulse` or `vdPulse` gets column 0.
- R4: With `modeSel` = 0, the row bit is the line parity. `vdPulse` makes the line even. The first `hdPulse` after a `vdPulse` or after reset starts an even line. Every later `hdPulse` flips the parity.
- R5: With `modeSel` = 1, the row bit is the field parity. The field is even after reset. The first `vdPulse` after reset leaves it even, and every later `vdPulse` toggles it. `hdPulse` does not change it.
- R6: `gainValid` is high exactly in the cycle after a cycle with `pixValid` high, and `chanOut`/`gainOut` update in that same cycle.
- R7: When `pixValid` is low, `chanOut` and `gainOut` hold their last values.
- R8: Each `hdPulse` loads all gain codes into the shadow bank. A pixel in the same cycle as `hdPulse` already uses the new codes. Changes to `gainCodes` between line starts have no effect on `gainOut`.
- R9: Line parity and field parity are both tracked in either mode. `modeSel` picks the row source at each pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel present this cycle |
| hdPulse | input | 1 | Line start, one cycle |
| vdPulse | input | 1 | Frame/field start, one cycle |
| modeSel | input | 1 | 0 line-alternating, 1 field-alternating |
| gainCodes | input | 4*GAIN_W | Four packed gain codes, channel 0 in the low bits |
| gainValid | output | 1 | Output pair is new this cycle |
| chanOut | output | 2 | Selected channel index |
| gainOut | output | GAIN_W | Selected gain code |

## Verification
The bench targets pixels that coincide with a sync pulse. A design that applies the sync one cycle late would give that pixel column 1 or stale gains. It also targets a vertical sync followed by a horizontal sync: a design that counts that line start as a parity flip would steer the first line to the odd pair. Mid-line gain writes are checked so that a missing shadow bank shows up as a gain change within the line. Idle gaps are checked so that a design that advances the column on invalid cycles breaks the alternation. A mode switch in the middle of a frame shows whether both parities are really kept, and the first vertical sync after reset must not move the field to odd.

// File: rtl/cfa_steer_pkg.sv
package cfa_steer_pkg;

  // A 2x2 mosaic always gives four channels
  localparam int NUM_CHAN = 4;
  localparam int CHAN_W   = $clog2(NUM_CHAN);

  typedef enum logic {
    MODE_LINE  = 1'b0,
    MODE_FIELD = 1'b1
  } steer_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              loadShadow;
    logic              pixStrobe;
    logic [CHAN_W-1:0] chanSel;
  } steer_t;

endpackage

// File: rtl/cfa_steer_ctrl.sv
module cfa_steer_ctrl
  import cfa_steer_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   pixValid,
  input  logic   hdPulse,
  input  logic   vdPulse,
  input  logic   modeSel,
  output steer_t steer
);

  logic colQ, lineOddQ, fieldOddQ, seenVdQ, armedQ;
  logic colNow, lineNow, fieldNow, rowNow;
  steer_mode_e modeNow;

  always_comb begin
    modeNow = steer_mode_e'(modeSel);
    colNow  = (hdPulse || vdPulse) ? 1'b0 : colQ;

    if (vdPulse)      lineNow = 1'b0;
    else if (hdPulse) lineNow = armedQ ? 1'b0 : ~lineOddQ;
    else              lineNow = lineOddQ;

    if (vdPulse) fieldNow = seenVdQ ? ~fieldOddQ : 1'b0;
    else         fieldNow = fieldOddQ;

    rowNow = (modeNow == MODE_FIELD) ? fieldNow : lineNow;

    steer.loadShadow = hdPulse;
    steer.pixStrobe  = pixValid;
    steer.chanSel    = {rowNow, colNow};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colQ      <= 1'b0;
      lineOddQ  <= 1'b0;
      fieldOddQ <= 1'b0;
      seenVdQ   <= 1'b0;
      armedQ    <= 1'b1;
    end else begin
      colQ      <= pixValid ? ~colNow : colNow;
      lineOddQ  <= lineNow;
      fieldOddQ <= fieldNow;
      seenVdQ   <= seenVdQ | vdPulse;
      if (vdPulse && !hdPulse) armedQ <= 1'b1;
      else if (hdPulse)        armedQ <= 1'b0;
    end
  end

  // R3: a pixel at a sync pulse is column 0
  p_col_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && (hdPulse || vdPulse)) |-> (steer.chanSel[0] == 1'b0));

  // R3: back-to-back pixels within a line alternate columns
  p_col_alternate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(pixValid) && !hdPulse && !vdPulse)
      |-> (steer.chanSel[0] != $past(steer.chanSel[0])));

  // R4: in line mode a pixel at vertical sync is on an even line
  p_vd_even_line_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && vdPulse && modeSel == 1'b0) |-> (steer.chanSel == '0));

  // R5: horizontal sync alone never moves the field
  p_field_steady_r5: assert property (@(posedge clk) disable iff (!rstN)
    !vdPulse |=> $stable(fieldOddQ));

endmodule

// File: rtl/cfa_steer_dp.sv
module cfa_steer_dp
  import cfa_steer_pkg::*;
#(
  parameter int GAIN_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  steer_t                     steer,
  input  logic [NUM_CHAN*GAIN_W-1:0] gainCodes,
  output logic                       gainValid,
  output logic [CHAN_W-1:0]          chanOut,
  output logic [GAIN_W-1:0]          gainOut
);

  logic [GAIN_W-1:0] shadowQ [NUM_CHAN];
  logic [GAIN_W-1:0] effGain [NUM_CHAN];

  for (genvar k = 0; k < NUM_CHAN; k++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)                 shadowQ[k] <= '0;
      else if (steer.loadShadow) shadowQ[k] <= gainCodes[k*GAIN_W +: GAIN_W];
    end

    // line start forwards the fresh codes to a coincident pixel
    assign effGain[k] = steer.loadShadow ? gainCodes[k*GAIN_W +: GAIN_W]
                                         : shadowQ[k];

    // R8: the bank only moves at a line start
    p_shadow_steady_r8: assert property (@(posedge clk) disable iff (!rstN)
      !steer.loadShadow |=> $stable(shadowQ[k]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainValid <= 1'b0;
      chanOut   <= '0;
      gainOut   <= '0;
    end else begin
      gainValid <= steer.pixStrobe;
      if (steer.pixStrobe) begin
        chanOut <= steer.chanSel;
        gainOut <= effGain[steer.chanSel];
      end
    end
  end

  // R6: output strobe trails the pixel by one clock
  p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    steer.pixStrobe |=> gainValid);
  p_valid_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !steer.pixStrobe |=> !gainValid);

  // R7: outputs hold through idle cycles
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !steer.pixStrobe |=> ($stable(chanOut) && $stable(gainOut)));

endmodule

// File: rtl/cfa_gain_steer.sv
module cfa_gain_steer
  import cfa_steer_pkg::*;
#(
  parameter int GAIN_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pixValid,
  input  logic                       hdPulse,
  input  logic                       vdPulse,
  input  logic                       modeSel,
  input  logic [NUM_CHAN*GAIN_W-1:0] gainCodes,
  output logic                       gainValid,
  output logic [CHAN_W-1:0]          chanOut,
  output logic [GAIN_W-1:0]          gainOut
);

  steer_t steer;

  cfa_steer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pixValid (pixValid),
    .hdPulse  (hdPulse),
    .vdPulse  (vdPulse),
    .modeSel  (modeSel),
    .steer    (steer)
  );

  cfa_steer_dp #(.GAIN_W(GAIN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .steer     (steer),
    .gainCodes (gainCodes),
    .gainValid (gainValid),
    .chanOut   (chanOut),
    .gainOut   (gainOut)
  );

endmodule

// File: tb/tb_cfa_gain_steer.sv
module tb_cfa_gain_steer;
  localparam int GW = 6;

  logic clk = 1'b0;
  logic rstN, pixValid, hdPulse, vdPulse, modeSel;
  logic [4*GW-1:0] gainCodes;
  logic gainValid;
  logic [1:0] chanOut;
  logic [GW-1:0] gainOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [GW-1:0] pend [4];
  logic [GW-1:0] active [4];

  always #2 clk = ~clk;

  cfa_gain_steer #(.GAIN_W(GW)) dut (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .hdPulse(hdPulse),
    .vdPulse(vdPulse), .modeSel(modeSel), .gainCodes(gainCodes),
    .gainValid(gainValid), .chanOut(chanOut), .gainOut(gainOut)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setGains(int g0, int g1, int g2, int g3);
    pend[0] = GW'(g0); pend[1] = GW'(g1); pend[2] = GW'(g2); pend[3] = GW'(g3);
    gainCodes = {pend[3], pend[2], pend[1], pend[0]};
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pixValid = 0; hdPulse = 0; vdPulse = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) active[i] = '0;
  endtask

  task automatic sync(bit hd, bit vd);
    @(negedge clk);
    hdPulse = hd; vdPulse = vd; pixValid = 0;
    if (hd) for (int i = 0; i < 4; i++) active[i] = pend[i];
    @(negedge clk);
    hdPulse = 0; vdPulse = 0;
  endtask

  task automatic pix(bit hd, bit vd, int expChan, string req);
    @(negedge clk);
    pixValid = 1; hdPulse = hd; vdPulse = vd;
    if (hd) for (int i = 0; i < 4; i++) active[i] = pend[i];
    @(negedge clk);
    pixValid = 0; hdPulse = 0; vdPulse = 0;
    chk({req, " valid"}, int'(gainValid), 1);
    chk({req, " chan"}, int'(chanOut), expChan);
    chk({req, " gain"}, int'(gainOut), int'(active[expChan]));
  endtask

  task automatic burst(int n, int row, string req);
    @(negedge clk);
    pixValid = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n - 1) pixValid = 0;
      chk({req, " burst chan"}, int'(chanOut), row * 2 + (i % 2));
      chk({req, " burst gain"}, int'(gainOut), int'(active[row * 2 + (i % 2)]));
    end
  endtask

  task automatic testReset();
    doReset();
    chk("R1 gainValid", int'(gainValid), 0);
    chk("R1 chanOut", int'(chanOut), 0);
    chk("R1 gainOut", int'(gainOut), 0);
    pix(0, 0, 0, "R1 shadow zero");
  endtask

  task automatic testLineMode();
    doReset();
    modeSel = 0;
    setGains(5, 10, 20, 40);
    sync(0, 1);
    sync(1, 0);
    burst(4, 0, "R4 even line R2 R3");
    sync(1, 0);
    burst(3, 1, "R4 odd line");
    pix(1, 0, 0, "R3 pixel at line start");
    pix(0, 0, 1, "R3 second pixel");
  endtask

  task automatic testIdleHold();
    doReset();
    modeSel = 0;
    setGains(7, 14, 21, 28);
    sync(1, 0);
    pix(0, 0, 0, "R6 first");
    repeat (3) begin
      @(negedge clk);
      chk("R6 idle valid low", int'(gainValid), 0);
      chk("R7 chan held", int'(chanOut), 0);
      chk("R7 gain held", int'(gainOut), 7);
    end
    pix(0, 0, 1, "R3 gap does not advance");
  endtask

  task automatic testMidLineWrite();
    doReset();
    modeSel = 0;
    setGains(1, 2, 3, 4);
    sync(1, 0);
    pix(0, 0, 0, "R8 before write");
    setGains(50, 51, 52, 53);
    pix(0, 0, 1, "R8 mid-line write ignored");
    chk("R8 old gain kept", int'(gainOut), 2);
    pix(1, 0, 2, "R8 new codes at line start");
    chk("R8 new gain used", int'(gainOut), 52);
  endtask

  task automatic testFieldMode();
    doReset();
    modeSel = 1;
    setGains(9, 18, 27, 36);
    sync(0, 1);
    sync(1, 0);
    burst(2, 0, "R5 first field even");
    sync(1, 0);
    burst(2, 0, "R5 hd keeps field");
    sync(0, 1);
    sync(1, 0);
    burst(2, 1, "R5 second field odd");
    sync(1, 0);
    burst(2, 1, "R5 odd field next line");
    sync(0, 1);
    pix(1, 0, 0, "R5 third field even");
  endtask

  task automatic testVdRestart();
    doReset();
    modeSel = 0;
    setGains(3, 6, 12, 24);
    sync(1, 0);
    sync(1, 0);
    pix(0, 0, 2, "R4 odd line first");
    pix(0, 1, 0, "R4 pixel at vd even col0");
    pix(1, 0, 0, "R4 first hd after vd even");
    sync(1, 0);
    pix(0, 0, 2, "R4 next hd odd");
  endtask

  task automatic testModeSwitch();
    doReset();
    modeSel = 0;
    setGains(11, 22, 33, 44);
    sync(0, 1);
    sync(1, 0);
    sync(1, 0);
    pix(0, 0, 2, "R9 odd line");
    modeSel = 1;
    pix(0, 0, 1, "R9 field row even");
    modeSel = 0;
    pix(0, 0, 2, "R9 line parity kept");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; pixValid = 0; hdPulse = 0; vdPulse = 0; modeSel = 0;
    gainCodes = '0;
    for (int i = 0; i < 4; i++) begin pend[i] = '0; active[i] = '0; end
    testReset();
    testLineMode();
    testIdleHold();
    testMidLineWrite();
    testFieldMode();
    testVdRestart();
    testModeSwitch();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule